// File: doc/BRIEF.md
# Port Jabber and Partition Guard

This block watches a single port of a multi-port repeater and isolates that port when it misbehaves. Two faults are covered. A receive that stays active for too long is a jabber fault. A run of collisions that is never broken by a clean frame is a partition fault. Either fault pulls down a port-enable output, and the repeater core uses that output to gate the port's receive and transmit paths. The other ports keep running.

All timing is measured in bit times. A single-cycle strobe marks each bit time, so one netlist serves both 10 Mb/s and 100 Mb/s ports. A five-port repeater places five independent copies of this block. A jabber fault clears as soon as carrier drops. A partition fault clears only after the port carries a long frame with no collision in it.

Top module: `port_fault_guard`

## Requirements
- R1: While reset is asserted and just after it is released, `jabber_o` and `part_o` are 0 and `port_en_o` is 1.
- R2: `jabber_o` rises in the cycle after the 65,537th `bit_tick` of one continuous carrier event (`crs` held 1). After exactly 65,536 ticks it is still 0.
- R3: The timers advance only on cycles where `bit_tick` is 1. A carrier held for any number of clocks without ticks neither raises `jabber_o` nor counts as a long clean frame.
- R4: `jabber_o` falls in the cycle after `crs` goes to 0. The next carrier event counts its bit times again from zero.
- R5: `port_en_o` is 0 whenever `jabber_o` or `part_o` is 1, and 1 otherwise.
- R6: Each 0-to-1 transition of `col` is one collision event. `part_o` rises in the cycle after the 64th consecutive collision event. After 63 such events it is still 0.
- R7: A carrier event ends on the cycle where `crs` goes from 1 to 0. A partitioned port is released, with `part_o` falling in the cycle after that end, only when the event saw no `col` and lasted at least 513 ticks. An event of exactly 512 ticks leaves the port partitioned.
- R8: A carrier event that ends with no collision and at least 513 ticks resets the consecutive-collision count. The 64 events needed for partition then start again from zero.
- R9: Carrier events that end clean but with 512 ticks or fewer leave the consecutive-collision count unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| crs | input | 1 | Port carrier sense, synchronous to `clk` |
| col | input | 1 | Port collision indication, synchronous to `clk` |
| bit_tick | input | 1 | One-cycle strobe per bit time |
| jabber_o | output | 1 | Port is in the jabber condition |
| part_o | output | 1 | Port is partitioned |
| port_en_o | output | 1 | Receive/transmit enable for the port |

## Verification
A long carrier is stepped tick by tick up to 65,536 and then one tick further. This shows exactly where the jabber cutoff sits. The carrier is then dropped and raised again, which shows that the timer restarts rather than resuming. Collision bursts of 63 and 64 events locate the partition threshold. Those bursts are split by three kinds of clean frame: a frame with carrier but no ticks, a 512-tick frame and a 513-tick frame. Together these separate "clock cycles" from "bit times", and a frame that is too short from one that is long enough to reset the count or release the port. A behavioural model runs in parallel on every clock, so any stray change of a flag outside these marked points is also caught.

// File: rtl/pfg_pkg.sv
package pfg_pkg;

  // Defaults shared by the guard and its sub-blocks
  localparam int unsigned PFG_JAB_LIMIT_DEF = 65536;
  localparam int unsigned PFG_PART_COLS_DEF = 64;
  localparam int unsigned PFG_CLEAN_LEN_DEF = 512;

  // Summary of a carrier event, valid in the cycle its carrier drops
  typedef struct packed {
    logic ended;        // carrier went from 1 to 0 this cycle
    logic had_col;      // a collision was seen during the event
    logic long_enough;  // more than CLEAN_LEN bit times elapsed
  } pfg_evt_t;

endpackage

// File: rtl/pfg_carrier_tracker.sv
module pfg_carrier_tracker
  import pfg_pkg::*;
#(
  parameter int unsigned CLEAN_LEN = PFG_CLEAN_LEN_DEF
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     crs,
  input  logic     col,
  input  logic     bit_tick,
  output pfg_evt_t evt_o,
  output logic     col_edge_o
);

  localparam int unsigned LW = $clog2(CLEAN_LEN + 2);
  localparam logic [LW-1:0] LEN_SAT = LW'(CLEAN_LEN + 1);

  logic          crs_q, crs_d;
  logic          col_q, col_d;
  logic          hit_q, hit_d;
  logic [LW-1:0] len_q, len_d;

  // Next-state logic
  always_comb begin
    crs_d = crs;
    col_d = col;
    if (crs) begin
      hit_d = hit_q | col;
      if (bit_tick && (len_q != LEN_SAT)) begin
        len_d = len_q + 1'b1;
      end else begin
        len_d = len_q;
      end
    end else begin
      hit_d = 1'b0;
      len_d = '0;
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crs_q <= 1'b0;
      col_q <= 1'b0;
      hit_q <= 1'b0;
      len_q <= '0;
    end else begin
      crs_q <= crs_d;
      col_q <= col_d;
      hit_q <= hit_d;
      len_q <= len_d;
    end
  end

  always_comb begin
    evt_o.ended       = crs_q & ~crs;
    evt_o.had_col     = hit_q | col;
    evt_o.long_enough = (len_q == LEN_SAT);
    col_edge_o        = col & ~col_q;
  end

endmodule

// File: rtl/pfg_jabber_timer.sv
module pfg_jabber_timer
  import pfg_pkg::*;
#(
  parameter int unsigned JAB_LIMIT = PFG_JAB_LIMIT_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic crs,
  input  logic bit_tick,
  output logic jabber_o
);

  localparam int unsigned CW = $clog2(JAB_LIMIT + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(JAB_LIMIT);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          jab_q, jab_d;
  logic          at_max;

  assign at_max = (cnt_q == CNT_MAX);

  // Next-state logic: saturating count, restarted with every carrier
  always_comb begin
    if (crs) begin
      if (bit_tick && !at_max) begin
        cnt_d = cnt_q + 1'b1;
      end else begin
        cnt_d = cnt_q;
      end
      jab_d = jab_q | (bit_tick & at_max);
    end else begin
      cnt_d = '0;
      jab_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      jab_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      jab_q <= jab_d;
    end
  end

  assign jabber_o = jab_q;

endmodule

// File: rtl/pfg_partition_ctrl.sv
module pfg_partition_ctrl
  import pfg_pkg::*;
#(
  parameter int unsigned PART_COLS = PFG_PART_COLS_DEF
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     col_edge,
  input  pfg_evt_t evt,
  output logic     part_o
);

  localparam int unsigned CCW = $clog2(PART_COLS + 1);
  localparam logic [CCW-1:0] CC_MAX  = CCW'(PART_COLS);
  localparam logic [CCW-1:0] CC_LAST = CCW'(PART_COLS - 1);

  logic [CCW-1:0] cc_q, cc_d;
  logic           part_q, part_d;
  logic           clean_end;

  assign clean_end = evt.ended & ~evt.had_col & evt.long_enough;

  // Next-state logic
  always_comb begin
    cc_d   = cc_q;
    part_d = part_q;
    if (clean_end) begin
      cc_d   = '0;
      part_d = 1'b0;
    end else if (col_edge) begin
      if (cc_q != CC_MAX) begin
        cc_d = cc_q + 1'b1;
      end
      if (cc_q >= CC_LAST) begin
        part_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cc_q   <= '0;
      part_q <= 1'b0;
    end else begin
      cc_q   <= cc_d;
      part_q <= part_d;
    end
  end

  assign part_o = part_q;

endmodule

// File: rtl/port_fault_guard.sv
module port_fault_guard
  import pfg_pkg::*;
#(
  parameter int unsigned JAB_LIMIT = PFG_JAB_LIMIT_DEF,
  parameter int unsigned PART_COLS = PFG_PART_COLS_DEF,
  parameter int unsigned CLEAN_LEN = PFG_CLEAN_LEN_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic crs,
  input  logic col,
  input  logic bit_tick,
  output logic jabber_o,
  output logic part_o,
  output logic port_en_o
);

  pfg_evt_t evt;
  logic     col_edge;
  logic     jab;
  logic     part;

  pfg_carrier_tracker #(.CLEAN_LEN(CLEAN_LEN)) u_trk (
    .clk        (clk),
    .rst_n      (rst_n),
    .crs        (crs),
    .col        (col),
    .bit_tick   (bit_tick),
    .evt_o      (evt),
    .col_edge_o (col_edge)
  );

  pfg_jabber_timer #(.JAB_LIMIT(JAB_LIMIT)) u_jab (
    .clk      (clk),
    .rst_n    (rst_n),
    .crs      (crs),
    .bit_tick (bit_tick),
    .jabber_o (jab)
  );

  pfg_partition_ctrl #(.PART_COLS(PART_COLS)) u_part (
    .clk      (clk),
    .rst_n    (rst_n),
    .col_edge (col_edge),
    .evt      (evt),
    .part_o   (part)
  );

  assign jabber_o  = jab;
  assign part_o    = part;
  assign port_en_o = ~(jab | part);

endmodule

// File: rtl/pfg_checker.sv
module pfg_checker (
  input logic clk,
  input logic rst_n,
  input logic crs,
  input logic col,
  input logic bit_tick,
  input logic jabber_o,
  input logic part_o,
  input logic port_en_o
);

  // R4: a dropped carrier always clears jabber on the next cycle
  a_r4_no_jab_without_carrier: assert property (
    @(posedge clk) disable iff (!rst_n) !crs |=> !jabber_o);

  // R2: jabber can only begin on a ticked cycle of an active carrier
  a_r2_jab_rise_on_tick: assert property (
    @(posedge clk) disable iff (!rst_n) $rose(jabber_o) |-> $past(crs && bit_tick));

  // R3: without a tick during carrier, the jabber flag cannot move
  a_r3_jab_holds_without_tick: assert property (
    @(posedge clk) disable iff (!rst_n) (crs && !bit_tick) |=> $stable(jabber_o));

  // R6: partition only starts on a cycle with a collision present
  a_r6_part_rise_on_col: assert property (
    @(posedge clk) disable iff (!rst_n) $rose(part_o) |-> $past(col));

  // R7: release only at the end of a carrier event with no collision
  a_r7_part_fall_at_end: assert property (
    @(posedge clk) disable iff (!rst_n) $fell(part_o) |-> $past(!crs && !col));

  // R5: enable returns only when one of the fault flags clears
  a_r5_en_rise_on_clear: assert property (
    @(posedge clk) disable iff (!rst_n)
      $rose(port_en_o) |-> ($fell(jabber_o) || $fell(part_o)));

endmodule

bind port_fault_guard pfg_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .crs       (crs),
  .col       (col),
  .bit_tick  (bit_tick),
  .jabber_o  (jabber_o),
  .part_o    (part_o),
  .port_en_o (port_en_o)
);

// File: tb/tb_port_fault_guard.sv
`timescale 1ns/1ps
module tb_port_fault_guard;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic crs = 1'b0;
  logic col = 1'b0;
  logic bit_tick = 1'b0;
  logic jabber_o, part_o, port_en_o;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 1'b0;

  // Behavioural reference state
  int m_run = 0;
  bit m_hit = 0;
  bit m_crs_prev = 0;
  bit m_col_prev = 0;
  int m_cc = 0;
  bit m_jab = 0;
  bit m_part = 0;

  port_fault_guard dut (
    .clk(clk), .rst_n(rst_n), .crs(crs), .col(col), .bit_tick(bit_tick),
    .jabber_o(jabber_o), .part_o(part_o), .port_en_o(port_en_o)
  );

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // Reference model, updated on the same edge as the design
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_run = 0; m_hit = 0; m_crs_prev = 0; m_col_prev = 0;
      m_cc = 0; m_jab = 0; m_part = 0;
    end else begin
      if (m_crs_prev && !crs) begin
        if (!m_hit && !col && m_run > 512) begin
          m_cc = 0;
          m_part = 0;
        end
        m_run = 0;
        m_hit = 0;
      end
      if (crs) begin
        if (bit_tick) m_run++;
        if (col) m_hit = 1;
      end
      m_jab = crs && (m_run > 65536);
      if (col && !m_col_prev) begin
        m_cc++;
        if (m_cc >= 64) m_part = 1;
      end
      m_crs_prev = crs;
      m_col_prev = col;
    end
  end

  // Cycle-by-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(jabber_o == m_jab, "R2/R4 model jabber", jabber_o, m_jab);
      chk(part_o == m_part, "R6/R7 model partition", part_o, m_part);
      chk(port_en_o == !(m_jab || m_part), "R5 model enable", port_en_o, !(m_jab || m_part));
    end
  end

  // Watchdog
  always @(posedge clk) begin
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected under 150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic collide();
    crs = 1'b1; col = 1'b1;
    @(negedge clk);
    crs = 1'b0; col = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic collisions(input int n);
    for (int i = 0; i < n; i++) collide();
  endtask

  task automatic clean_frame(input int ticks);
    crs = 1'b1; bit_tick = 1'b1;
    repeat (ticks) @(negedge clk);
    crs = 1'b0; bit_tick = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    chk(jabber_o == 1'b0, "R1 reset jabber", jabber_o, 0);
    chk(part_o == 1'b0, "R1 reset partition", part_o, 0);
    chk(port_en_o == 1'b1, "R1 reset enable", port_en_o, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(port_en_o == 1'b1, "R1 enable after release", port_en_o, 1);

    // R6 / R9 / R3: 63 collisions, short and tickless clean frames, then one more
    collisions(63);
    chk(part_o == 1'b0, "R6 after 63 collisions", part_o, 0);
    clean_frame(512);
    crs = 1'b1;
    repeat (700) @(negedge clk);
    crs = 1'b0;
    @(negedge clk);
    chk(part_o == 1'b0, "R3 tickless carrier", part_o, 0);
    crs = 1'b1; col = 1'b1;
    @(negedge clk);
    chk(part_o == 1'b1, "R9 64th collision partitions", part_o, 1);
    chk(port_en_o == 1'b0, "R5 enable low when partitioned", port_en_o, 0);
    crs = 1'b0; col = 1'b0;
    @(negedge clk);

    // R7: 512-tick frame keeps partition, 513-tick frame releases it
    clean_frame(512);
    chk(part_o == 1'b1, "R7 512 ticks keeps partition", part_o, 1);
    clean_frame(513);
    chk(part_o == 1'b0, "R7 513 ticks releases", part_o, 0);
    chk(port_en_o == 1'b1, "R5 enable back", port_en_o, 1);

    // R8: a long clean frame restarts the count
    collisions(63);
    clean_frame(513);
    collisions(63);
    chk(part_o == 1'b0, "R8 count restarted", part_o, 0);
    collisions(1);
    chk(part_o == 1'b1, "R8 partition after 64 fresh", part_o, 1);
    clean_frame(600);
    chk(part_o == 1'b0, "R7 release again", part_o, 0);

    // R2 / R3 / R4: jabber boundary
    crs = 1'b1; bit_tick = 1'b1;
    repeat (65536) @(negedge clk);
    chk(jabber_o == 1'b0, "R2 65536 ticks no jabber", jabber_o, 0);
    @(negedge clk);
    chk(jabber_o == 1'b1, "R2 65537th tick jabbers", jabber_o, 1);
    chk(port_en_o == 1'b0, "R5 enable low when jabbered", port_en_o, 0);
    chk(part_o == 1'b0, "R2 jabber leaves partition alone", part_o, 0);
    bit_tick = 1'b0;
    repeat (5) @(negedge clk);
    chk(jabber_o == 1'b1, "R3 jabber held without ticks", jabber_o, 1);
    crs = 1'b0;
    @(negedge clk);
    chk(jabber_o == 1'b0, "R4 jabber clears on carrier drop", jabber_o, 0);
    chk(port_en_o == 1'b1, "R5 enable after jabber", port_en_o, 1);
    crs = 1'b1; bit_tick = 1'b1;
    repeat (10) @(negedge clk);
    chk(jabber_o == 1'b0, "R4 timer restarts", jabber_o, 0);
    crs = 1'b0; bit_tick = 1'b0;
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule